// File: doc/BRIEF.md
# Polyphase FIR Interpolator

This block raises the sample rate of a stream by an integer factor L. In theory that means inserting L-1 zero samples after every input and then passing the result through a prototype FIR filter g[m] of L*P taps. Here the prototype is split into L sub-filters of P taps each. Sub-filter k holds the taps g[k], g[k+L], g[k+2L], and so on. All sub-filters read the same short history of the last P input samples at the input rate. None of them ever multiplies a stuffed zero.

Input samples arrive on a valid/ready stream. After a sample is accepted, the block offers exactly L results on an output valid/ready stream, in phase order 0 to L-1. Result k of input n equals output sample L*n+k of the zero-stuffed direct-form filter. The accumulator is wide enough that no result is ever rounded, truncated or wrapped. The coefficients, L, P and the data and coefficient widths are all parameters.

Top module: `polyphase_interp`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1. Reset clears the sample history to zero.
- R2: A sample is accepted in a cycle where `in_valid` and `in_ready` are both 1. In the next cycle `in_ready` is 0 and `out_valid` is 1.
- R3: Each accepted sample produces exactly L output transfers. In the cycle after the L-th transfer, `out_valid` is 0 and `in_ready` is 1 again.
- R4: Let x[n] be the sample just accepted, with x[n-j] the earlier ones (zero before reset release). The k-th output transfer after it, counting from k=0, carries the sum over j=0..P-1 of g[k+j*L]*x[n-j].
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R6: `out_data` is a two's complement value DATA_W+COEF_W+clog2(P) bits wide. It holds every exact sum, including all inputs and taps at the most negative value.
- R7: With an empty history, a single sample of value 1 followed by zero samples returns the taps g[0], g[1], ..., g[L*P-1] in index order.
- R8: `in_valid` and `in_data` have no effect while `in_ready` is 0. The sample history and the pending outputs are unchanged.
- R9: Asserting reset between bursts discards all earlier samples. The next sample's outputs are computed as if the history were all zero.
- R10: The coefficient vector `COEFS` holds g[m] in bits [m*COEF_W +: COEF_W], as signed values. Sample and output data are signed two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer takes the output sample |
| out_data | output | DATA_W+COEF_W+clog2(P) | Full-precision signed output sample |

## Verification
A unit impulse into an empty history isolates each tap. It shows whether the phases are wired to the right coefficient subsets and emitted in the right order. An irregular sequence of mixed-sign samples mixes several history slots in each result, which exposes shift-order or sign errors that the impulse cannot. Samples and taps at the most negative value drive the phase-0 sum to its largest magnitude, so any narrowed accumulator shows up. Backpressure, input offered while busy, and a mid-stream reset separate correct holding and discarding from a block that merely computes the right sums.

// File: rtl/pfi_pkg.sv
package pfi_pkg;

    // Operating mode of the output sequencer
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_EMIT = 1'b1
    } seq_mode_e;

    // Accumulator width that holds any exact sum of taps products
    function automatic int acc_width(input int data_w, input int coef_w, input int taps);
        return data_w + coef_w + $clog2(taps);
    endfunction

    // Width of a phase index for an interpolation factor
    function automatic int phase_width(input int factor);
        return (factor > 1) ? $clog2(factor) : 1;
    endfunction

endpackage

// File: rtl/pfi_history.sv
module pfi_history #(
    parameter int DATA_W = 16,
    parameter int P      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [DATA_W-1:0]   din,
    output logic [P*DATA_W-1:0] hist
);

    typedef struct packed {
        logic [P-1:0][DATA_W-1:0] slot;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.slot[0] = din;
            for (int i = 1; i < P; i++) begin
                st_d.slot[i] = st_q.slot[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // slot 0 is the newest sample, slot P-1 the oldest
    assign hist = st_q.slot;

    // R9: the history is empty right after reset
    assert_hist_clear_R9: assert property (@(posedge clk)
        $rose(rst_n) |-> (hist == '0));

endmodule

// File: rtl/pfi_sequencer.sv
module pfi_sequencer #(
    parameter int L = 4,
    localparam int PH_W = pfi_pkg::phase_width(L)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            out_ready,
    output logic            in_ready,
    output logic            out_valid,
    output logic            accept,
    output logic [PH_W-1:0] phase
);
    import pfi_pkg::*;

    localparam logic [PH_W-1:0] LAST_PH = PH_W'(L - 1);

    typedef struct packed {
        seq_mode_e       mode;
        logic [PH_W-1:0] ph;
    } seq_t;

    seq_t st_d, st_q;
    logic take;

    assign in_ready  = (st_q.mode == SEQ_IDLE);
    assign out_valid = (st_q.mode == SEQ_EMIT);
    assign accept    = in_valid && in_ready;
    assign take      = out_valid && out_ready;
    assign phase     = st_q.ph;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.mode = SEQ_EMIT;
            st_d.ph   = '0;
        end else if (take) begin
            if (st_q.ph == LAST_PH) begin
                st_d.mode = SEQ_IDLE;
                st_d.ph   = '0;
            end else begin
                st_d.ph = st_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: SEQ_IDLE, ph: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the transfer of the last phase closes the burst
    assert_burst_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && phase == LAST_PH) |=> (!out_valid && in_ready));

    // R4: phases advance one step per transfer inside a burst
    assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && phase != LAST_PH)
            |=> (out_valid && phase == PH_W'($past(phase) + 1'b1)));

    // R4: every burst starts at phase zero
    assert_phase_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (phase == '0));

endmodule

// File: rtl/pfi_branch_mac.sv
module pfi_branch_mac #(
    parameter int L      = 4,
    parameter int P      = 4,
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter logic [L*P*COEF_W-1:0] COEFS = '0,
    localparam int PH_W  = pfi_pkg::phase_width(L),
    localparam int ACC_W = pfi_pkg::acc_width(DATA_W, COEF_W, P)
) (
    input  logic [P*DATA_W-1:0] hist,
    input  logic [PH_W-1:0]     phase,
    output logic [ACC_W-1:0]    acc
);

    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [PROD_W-1:0] prod [P];

    // One multiplier per tap of a sub-filter; the phase picks which taps it uses
    for (genvar j = 0; j < P; j++) begin : g_tap
        logic signed [DATA_W-1:0] sample;
        logic signed [COEF_W-1:0] coef;

        assign sample = $signed(hist[j*DATA_W +: DATA_W]);

        always_comb begin
            coef = '0;
            for (int k = 0; k < L; k++) begin
                if (int'(phase) == k) begin
                    coef = $signed(COEFS[(k + j*L)*COEF_W +: COEF_W]);
                end
            end
        end

        assign prod[j] = sample * coef;
    end

    // R6: every sum is built at the full accumulator width
    always_comb begin
        logic signed [ACC_W-1:0] sum;
        sum = '0;
        for (int j = 0; j < P; j++) begin
            sum = sum + ACC_W'(prod[j]);
        end
        acc = sum;
    end

endmodule

// File: rtl/polyphase_interp.sv
module polyphase_interp #(
    parameter int L      = 4,
    parameter int P      = 4,
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter logic [L*P*COEF_W-1:0] COEFS = {(L*P){ {{(COEF_W-1){1'b0}}, 1'b1} }},
    localparam int ACC_W = pfi_pkg::acc_width(DATA_W, COEF_W, P)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ACC_W-1:0]  out_data
);

    localparam int PH_W = pfi_pkg::phase_width(L);

    logic                accept;
    logic [PH_W-1:0]     phase;
    logic [P*DATA_W-1:0] hist;

    pfi_sequencer #(.L(L)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .accept    (accept),
        .phase     (phase)
    );

    pfi_history #(.DATA_W(DATA_W), .P(P)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   (in_data),
        .hist  (hist)
    );

    pfi_branch_mac #(
        .L(L), .P(P), .DATA_W(DATA_W), .COEF_W(COEF_W), .COEFS(COEFS)
    ) u_mac (
        .hist  (hist),
        .phase (phase),
        .acc   (out_data)
    );

    // R1: idle state when reset is released
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));

    // R2: an accepted sample opens a burst and blocks further input
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !in_ready));

    // R5: a stalled output holds its value
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: the history cannot move while input is refused
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(hist));

endmodule

// File: tb/test_polyphase_interp.sv
module test_polyphase_interp;

    localparam int L      = 4;
    localparam int P      = 4;
    localparam int DW     = 16;
    localparam int CW     = 16;
    localparam int AW     = DW + CW + 2;

    // g[m] packed with m=15 at the top (R10 layout)
    localparam logic [L*P*CW-1:0] TB_COEFS = {
        16'h8000, 16'h0002, 16'h0001, 16'h8000,
        16'hFFF9, 16'h0064, 16'h8001, 16'h8000,
        16'h0003, 16'hFFEC, 16'h7FFF, 16'h8000,
        16'h000E, 16'hFFF7, 16'h0005, 16'h8000
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [AW-1:0] out_data;

    int tests = 0;
    int fails = 0;
    longint hist_m [P];

    always #4ns clk = ~clk;

    polyphase_interp #(
        .L(L), .P(P), .DATA_W(DW), .COEF_W(CW), .COEFS(TB_COEFS)
    ) i_polyphase_interp (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic longint g(input int m);
        return longint'($signed(TB_COEFS[m*CW +: CW]));
    endfunction

    function automatic longint expect_phase(input int k);
        longint s = 0;
        for (int j = 0; j < P; j++) s += g(k + j*L) * hist_m[j];
        return s;
    endfunction

    function automatic longint got();
        return longint'($signed(out_data));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int j = 0; j < P; j++) hist_m[j] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 out_valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", longint'(out_valid), 0);
        check("R1 in_ready after reset", longint'(in_ready), 1);
        clear_model();
    endtask

    task automatic send(input logic signed [DW-1:0] x);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = x;
        @(negedge clk);
        in_valid = 1'b0;
        for (int j = P-1; j > 0; j--) hist_m[j] = hist_m[j-1];
        hist_m[0] = longint'(x);
        check("R2 busy after accept", longint'({out_valid, in_ready}), 2);
    endtask

    // Takes all L outputs, comparing each with the model; sampled at negedge
    task automatic drain(input string req);
        for (int k = 0; k < L; k++) begin
            check({req, " out_valid"}, longint'(out_valid), 1);
            check({req, " phase value"}, got(), expect_phase(k));
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
        check("R3 burst closed", longint'({out_valid, in_ready}), 1);
    endtask

    task automatic test_impulse();
        // R7: taps come back in index order
        send(16'sd1);
        for (int blk = 0; blk < P; blk++) begin
            for (int k = 0; k < L; k++) begin
                check("R7 impulse tap", got(), g(blk*L + k));
                out_ready = 1'b1;
                @(negedge clk);
                out_ready = 1'b0;
            end
            if (blk < P-1) send(16'sd0);
        end
    endtask

    task automatic test_mixed();
        logic signed [DW-1:0] seq [8] = '{16'sd1200, -16'sd77, 16'sd3, -16'sd30000,
                                          16'sd32767, 16'sd0, -16'sd5, 16'sd419};
        for (int i = 0; i < 8; i++) begin
            send(seq[i]);
            drain("R4 mixed");
        end
    endtask

    task automatic test_extreme();
        // R6: all phase-0 taps are -32768, so the phase-0 sum reaches 2^32
        for (int i = 0; i < P; i++) begin
            send(-16'sd32768);
            if (i < P-1) drain("R6 fill");
        end
        check("R6 full precision peak", got(), 64'sd4294967296);
        drain("R6 extreme");
    endtask

    task automatic test_backpressure();
        longint held;
        send(-16'sd901);
        out_ready = 1'b0;
        held = got();
        check("R5 first value", held, expect_phase(0));
        repeat (3) begin
            @(negedge clk);
            check("R5 valid held", longint'(out_valid), 1);
            check("R5 data held", got(), held);
        end
        drain("R5 after stall");
    endtask

    task automatic test_busy_ignore();
        send(16'sd250);
        in_valid = 1'b1; in_data = 16'sd9999;
        repeat (3) begin
            @(negedge clk);
            check("R8 refused while busy", longint'(in_ready), 0);
        end
        check("R8 phase0 unchanged", got(), expect_phase(0));
        for (int k = 0; k < L; k++) begin
            if (k == L-1) in_valid = 1'b0;
            check("R8 busy outputs", got(), expect_phase(k));
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
        in_valid = 1'b0;
        // a following sample reveals any stray history entry
        send(16'sd7);
        drain("R8 next burst");
    endtask

    task automatic test_reset_clear();
        send(16'sd12345);
        drain("R9 before reset");
        send(-16'sd2222);
        do_reset();
        send(16'sd1);
        for (int k = 0; k < L; k++) begin
            check("R9 history cleared", got(), g(k));
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_model();
        do_reset();
        test_impulse();
        test_mixed();
        test_extreme();
        test_backpressure();
        test_busy_ignore();
        test_reset_clear();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule